// File: doc/BRIEF.md
# Sticky Protection Lock Register

This block is a byte-wide host control register whose only live bit is a lock that, once written to 1, can be cleared only by the hardware reset input. The stored lock is combined with an external active-low lock pin, after that pin has passed through a flop synchronizer, to form one effective lock signal.

The effective lock is used in two places. The first is a per-partition unlock gate. For each partition, a key-match input may unlock it. When the effective lock is active and that partition's own lock flag is set, the match is vetoed. The second is a lock indication bit in a small read-only status register, which is also brought out as an output. Key storage, key comparison and the partition tables sit outside this block.

Top module: `prot_lock_reg`

## Requirements
- R1: After reset, a read of the control address (0xC) returns 0x01, `lock_active` is 0 while `lock_pin_n` is high, and a read of the status address (0xD) returns 0x00.
- R2: A write to the control address with data bit 3 set stores the sticky lock. `lock_active` is 1 from the cycle after the write edge. A write with bit 3 set to any other address does not store it.
- R3: Once stored, the sticky lock stays set through writes to the control address with bit 3 clear and through writes to other addresses. Only `rst_n` low clears it.
- R4: A read of the control address always returns 0x01, whatever was written and whether or not the sticky lock is stored. The lock bit 3 reads 0, and the reserved bits read their reset values.
- R5: `lock_pin_n` low sets `lock_active` after two clock edges of synchronization. Returning it high clears `lock_active` two edges later if the sticky lock is not stored.
- R6: For a partition whose `part_lock` bit is 1, `unlock_en` is 0 while `lock_active` is 1, even if `key_match` is 1. It equals `key_match` while `lock_active` is 0.
- R7: For a partition whose `part_lock` bit is 0, `unlock_en` equals `key_match` whatever the state of `lock_active`.
- R8: Status address reads return the effective lock in bit 0 and zeros elsewhere. `lock_active` carries the same value. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset; the only clear of the sticky lock |
| reg_addr | input | 4 | Register address for reads and writes |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| lock_pin_n | input | 1 | External active-low lock request (asynchronous) |
| part_lock | input | 4 | Per-partition lock flag |
| key_match | input | 4 | Per-partition key-match indication |
| unlock_en | output | 4 | Per-partition permission to disable protection |
| lock_active | output | 1 | Effective lock state |

## Verification
The assertions check several properties on every cycle:
- the sticky bit never falls outside reset,
- a qualified write always sets it,
- a control read always returns the fixed pattern,
- a vetoed partition never sees `unlock_en`, and an unflagged partition's `unlock_en` follows its key match,
- the stored sticky lock always appears on the status indication.

Some behaviours only the bench scenarios can show. These are the two-edge synchronizer latency in both directions, that a reset clears the lock, and that writes to other addresses are ignored. The bench also shows that clearing writes leave the lock set, as observed on `lock_active` and on register reads.

// File: rtl/prot_lock_pkg.sv
package prot_lock_pkg;
   typedef enum logic [1:0] {
      RSEL_NONE = 2'd0,
      RSEL_CTRL = 2'd1,
      RSEL_STAT = 2'd2
   } rsel_e;
endpackage

// File: rtl/plk_sync.sv
module plk_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 0) begin : g_bad_stages
      $error("plk_sync: STAGES must be non-negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL}};
         else if (STAGES == 1) chain[0] <= d;
         else chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
   end
endmodule

// File: rtl/plk_sticky.sv
module plk_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   output logic sticky
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sticky <= 1'b0;
      else if (set_req) sticky <= 1'b1;
   end

   // R3: outside reset the stored lock never falls
   assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sticky |=> sticky);
   // R2: a qualified write always leaves the lock stored
   assert_sticky_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      set_req |=> sticky);
endmodule

// File: rtl/plk_gate.sv
module plk_gate #(
   parameter int NPART = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lock_eff,
   input  logic [NPART-1:0] part_lock,
   input  logic [NPART-1:0] key_match,
   output logic [NPART-1:0] unlock_en
);
   if (NPART < 1) begin : g_bad_npart
      $error("plk_gate: NPART must be at least 1");
   end

   for (genvar p = 0; p < NPART; p++) begin : g_part
      logic veto;
      assign veto         = lock_eff & part_lock[p];
      assign unlock_en[p] = key_match[p] & ~veto;

      // R6: a flagged partition is never unlocked while the lock is active
      assert_veto_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (lock_eff && part_lock[p]) |-> !unlock_en[p]);
      // R7: an unflagged partition follows its key match
      assert_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !part_lock[p] |-> (unlock_en[p] == key_match[p]));
   end
endmodule

// File: rtl/prot_lock_reg.sv
module prot_lock_reg
   import prot_lock_pkg::*;
#(
   parameter int               ADDR_W        = 4,
   parameter int               DATA_W        = 8,
   parameter int               NPART         = 4,
   parameter int               SYNC_STAGES   = 2,
   parameter logic [ADDR_W-1:0] CTRL_ADDR    = 4'hC,
   parameter logic [ADDR_W-1:0] STAT_ADDR    = 4'hD,
   parameter int               LOCK_BIT      = 3,
   parameter int               STAT_LOCK_BIT = 0,
   parameter logic [DATA_W-1:0] CTRL_RST     = 8'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              lock_pin_n,
   input  logic [NPART-1:0]  part_lock,
   input  logic [NPART-1:0]  key_match,
   output logic [NPART-1:0]  unlock_en,
   output logic              lock_active
);
   localparam logic [DATA_W-1:0] LOCK_MASK = DATA_W'(1) << LOCK_BIT;

   if (LOCK_BIT >= DATA_W || STAT_LOCK_BIT >= DATA_W) begin : g_bad_bits
      $error("prot_lock_reg: bit positions exceed DATA_W");
   end
   if ((CTRL_RST & LOCK_MASK) != '0) begin : g_bad_rst
      $error("prot_lock_reg: lock bit must reset to 0");
   end
   if (CTRL_ADDR == STAT_ADDR) begin : g_bad_addr
      $error("prot_lock_reg: register addresses must differ");
   end

   logic  pin_n_sync;
   logic  sticky;
   logic  set_req;
   logic  lock_eff;
   rsel_e rsel;
   logic  unused_wdata;

   assign unused_wdata = ^reg_wdata;

   plk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (lock_pin_n),
      .q     (pin_n_sync)
   );

   assign set_req = reg_we && (reg_addr == CTRL_ADDR) && reg_wdata[LOCK_BIT];

   plk_sticky u_sticky (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req (set_req),
      .sticky  (sticky)
   );

   assign lock_eff    = sticky | ~pin_n_sync;
   assign lock_active = lock_eff;

   plk_gate #(.NPART(NPART)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .lock_eff  (lock_eff),
      .part_lock (part_lock),
      .key_match (key_match),
      .unlock_en (unlock_en)
   );

   always_comb begin
      if (reg_addr == CTRL_ADDR)      rsel = RSEL_CTRL;
      else if (reg_addr == STAT_ADDR) rsel = RSEL_STAT;
      else                            rsel = RSEL_NONE;
   end

   always_comb begin
      reg_rdata = '0;
      case (rsel)
         RSEL_CTRL: reg_rdata = CTRL_RST & ~LOCK_MASK;
         RSEL_STAT: reg_rdata[STAT_LOCK_BIT] = lock_eff;
         default:   reg_rdata = '0;
      endcase
   end

   // R4: the control register always reads its fixed pattern
   assert_ctrl_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == CTRL_ADDR) |-> (reg_rdata == CTRL_RST));
   // R8: a stored sticky lock always shows in the status indication
   assert_stat_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky && reg_addr == STAT_ADDR) |-> reg_rdata[STAT_LOCK_BIT]);
endmodule

// File: tb/prot_lock_reg_bench.sv
module prot_lock_reg_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] reg_addr = 4'h0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       lock_pin_n = 1'b1;
   logic [3:0] part_lock = 4'h0;
   logic [3:0] key_match = 4'h0;
   logic [3:0] unlock_en;
   logic       lock_active;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   prot_lock_reg u_prot_lock_reg (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lock_pin_n(lock_pin_n),
      .part_lock(part_lock), .key_match(key_match), .unlock_en(unlock_en),
      .lock_active(lock_active)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_we = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic read_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
      reg_addr = a;
      #1;
      chk(req, reg_rdata, exp);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset_state();
      do_reset();
      read_chk("R1 ctrl", 4'hC, 8'h01);
      chk("R1 lock_active", lock_active, 0);
      read_chk("R1 status", 4'hD, 8'h00);
      read_chk("R8 unmapped", 4'h3, 8'h00);
   endtask

   task automatic t_gate_unlocked();
      part_lock = 4'b0101; key_match = 4'b1111;
      #1;
      chk("R6 no lock flagged follow", unlock_en, 4'b1111);
      key_match = 4'b0110;
      #1;
      chk("R7 no lock", unlock_en, 4'b0110);
   endtask

   task automatic t_pin_lock();
      @(negedge clk);
      lock_pin_n = 1'b0;
      @(negedge clk);
      chk("R5 one edge still clear", lock_active, 0);
      @(negedge clk);
      chk("R5 two edges set", lock_active, 1);
      part_lock = 4'b0101; key_match = 4'b1111;
      #1;
      chk("R6 pin veto", unlock_en, 4'b1010);
      read_chk("R8 status pin", 4'hD, 8'h01);
      lock_pin_n = 1'b1;
      @(negedge clk);
      chk("R5 one edge still set", lock_active, 1);
      @(negedge clk);
      chk("R5 released", lock_active, 0);
   endtask

   task automatic t_sticky();
      do_write(4'hC, 8'h08);
      chk("R2 set after write", lock_active, 1);
      read_chk("R4 ctrl after set", 4'hC, 8'h01);
      read_chk("R8 status sticky", 4'hD, 8'h01);
      do_write(4'hC, 8'h00);
      do_write(4'hD, 8'hFF);
      do_write(4'h5, 8'h00);
      chk("R3 held", lock_active, 1);
      do_write(4'hC, 8'hF7);
      read_chk("R4 ctrl after F7", 4'hC, 8'h01);
      chk("R3 held F7", lock_active, 1);
      part_lock = 4'b1111; key_match = 4'b1111;
      #1;
      chk("R6 sticky veto", unlock_en, 4'b0000);
      part_lock = 4'b0000; key_match = 4'b0110;
      #1;
      chk("R7 under lock", unlock_en, 4'b0110);
   endtask

   task automatic t_reset_clear();
      do_reset();
      chk("R3 reset clears", lock_active, 0);
      do_write(4'h0, 8'h08);
      chk("R2 other address ignored", lock_active, 0);
      do_write(4'hD, 8'h08);
      read_chk("R2 status write ignored", 4'hD, 8'h00);
   endtask

   initial begin
      t_reset_state();
      t_gate_unlocked();
      t_pin_lock();
      t_sticky();
      t_reset_clear();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule